// File: doc/BRIEF.md
# Doubleword Load Execute Unit

This unit carries out one 64-bit load instruction at a time, from a family of four encodings. Two encodings use a scaled displacement and two use an index register. One of each pair also writes the effective address back to the base register. A single start strobe hands the unit a 32-bit instruction word and the current program counter. The unit reads the base and index registers through two combinational register-file read ports and forms the effective address. It then fetches eight bytes in ascending address order over a byte-wide memory read port, and writes back the assembled big-endian doubleword. In the update forms it then writes the effective address to the base register.

The memory port is a valid/ready stream. The unit raises `mem_req_valid` with an address and holds both steady until `mem_req_ready` is seen high at a clock edge. The byte on `mem_rsp_data` is taken in that same cycle. The memory side may hold ready low for any number of cycles and nothing is lost. Register writes use a plain one-cycle write strobe. A word that matches none of the four encodings produces a one-cycle illegal pulse and nothing else.

Top module: `ldd_exec_unit`

## Requirements
- R1: Bit 31 of the word is instruction bit 0. Destination index = word[25:21], base index = word[20:16], index register = word[15:11]. Primary opcode word[31:26] = 58 with word[1:0] = 0 is the plain displacement load, and with word[1:0] = 1 it is the displacement load with update. Primary opcode 31 with word[0] = 0 and word[10:1] = 21 is the plain indexed load, and with word[10:1] = 53 it is the indexed load with update.
- R2: Any other word causes `illegal` to be high for exactly the one cycle after the start edge. No memory request, register write or `done` follows.
- R3: In the displacement forms the offset is word[15:2] with two zero bits appended, sign-extended to 64 bits. In the indexed forms the offset is the index register value.
- R4: In the non-update forms, a base index of 0 selects a literal zero base. In the update forms, base index 0 reads register 0.
- R5: The effective address is the low 32 bits of the 64-bit wrapping sum of base and offset. The eight byte requests go to EA, EA+1 … EA+7 modulo 2^32, and an unaligned EA is accepted without any fault.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged. Exactly eight handshakes are made per legal instruction.
- R7: The byte taken at EA is the most significant byte of the 64-bit value, and the whole value is written to the destination register.
- R8: In the update forms a second write follows the destination write and puts the zero-extended EA into the base register. When base equals destination, that register ends holding the EA.
- R9: `done` is high for exactly one cycle, the cycle after the last register write. While `done` is high, `pc_next` equals the start PC plus 4.
- R10: A start strobe that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` (taken when idle) |
| instr | input | 32 | Instruction word |
| pc_in | input | 64 | Program counter of the instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unmatched-encoding pulse |
| pc_next | output | 64 | Start PC plus 4, valid while `done` |
| rf_a_idx | output | 5 | Base register read index |
| rf_a_data | input | 64 | Base register read data |
| rf_b_idx | output | 5 | Index register read index |
| rf_b_data | input | 64 | Index register read data |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts request; data valid this cycle |
| mem_req_addr | output | 32 | Byte address |
| mem_rsp_data | input | 8 | Byte returned on handshake |
| wb_en | output | 1 | Register write strobe |
| wb_idx | output | 5 | Register write index |
| wb_data | output | 64 | Register write data |

## Verification
Two events can fall in the same cycle here: a fresh start strobe can arrive while a byte request is stalled by back-pressure. The bench provokes this by driving ready on alternate cycles and strobing an unmatched word in the middle of a fetch. The run passes only if no illegal pulse appears and the loaded value, the address sequence and the write count match an undisturbed run. A second overlap arises with an update form whose base equals its destination, where both writes target one register on consecutive cycles. That case is judged on the final register holding the effective address.

// File: rtl/ldd_pkg.sv
package ldd_pkg;
  localparam int OPC_DISP  = 58;
  localparam int OPC_XFORM = 31;
  localparam int XO_INDEX  = 21;
  localparam int XO_INDEXU = 53;

  typedef struct packed {
    logic        legal;
    logic        upd;
    logic        idx;
    logic [4:0]  rt;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [13:0] ds;
  } ldd_op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_AGEN, S_FETCH, S_WR_DST, S_WR_BASE, S_DONE
  } ldd_state_t;
endpackage

// File: rtl/ldd_decode.sv
module ldd_decode
  import ldd_pkg::*;
(
  input  logic [31:0] instr,
  output ldd_op_t     op
);
  always_comb begin
    op    = '0;
    op.rt = instr[25:21];
    op.ra = instr[20:16];
    op.rb = instr[15:11];
    op.ds = instr[15:2];
    if (instr[31:26] == 6'(OPC_DISP)) begin
      // R1: low two bits pick plain (0) or update (1)
      op.legal = !instr[1];
      op.upd   = instr[0];
    end else if (instr[31:26] == 6'(OPC_XFORM) && !instr[0]) begin
      if (instr[10:1] == 10'(XO_INDEX)) begin
        op.legal = 1'b1;
        op.idx   = 1'b1;
      end else if (instr[10:1] == 10'(XO_INDEXU)) begin
        op.legal = 1'b1;
        op.idx   = 1'b1;
        op.upd   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldd_agen.sv
module ldd_agen #(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic            base_zero,
  input  logic            use_index,
  input  logic [13:0]     ds,
  input  logic [XLEN-1:0] a_val,
  input  logic [XLEN-1:0] b_val,
  output logic [AW-1:0]   ea
);
  localparam int SEXT = XLEN - 16;

  logic [XLEN-1:0] base, offs, sum;

  always_comb begin
    base = base_zero ? '0 : a_val;                          // R4
    offs = use_index ? b_val : {{SEXT{ds[13]}}, ds, 2'b00}; // R3
    sum  = base + offs;
    ea   = sum[AW-1:0];                                     // R5
  end
endmodule

// File: rtl/ldd_gather.sv
module ldd_gather #(
  parameter int NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  take,
  input  logic [7:0]            byte_in,
  output logic [8*NBYTES-1:0]   word,
  output logic [$clog2(NBYTES)-1:0] cnt,
  output logic                  last
);
  localparam int CW = $clog2(NBYTES);

  assign last = (cnt == CW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt  <= '0;
      word <= '0;
    end else if (take) begin
      cnt  <= cnt + 1'b1;
      word <= {word[8*NBYTES-9:0], byte_in}; // R7: first byte ends up on top
    end
  end

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last && !clear) |=> (cnt == '0));
endmodule

// File: rtl/ldd_exec_unit.sv
module ldd_exec_unit
  import ldd_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc_in,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [XLEN-1:0] pc_next,
  output logic [4:0]      rf_a_idx,
  input  logic [XLEN-1:0] rf_a_data,
  output logic [4:0]      rf_b_idx,
  input  logic [XLEN-1:0] rf_b_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic [7:0]      mem_rsp_data,
  output logic            wb_en,
  output logic [4:0]      wb_idx,
  output logic [XLEN-1:0] wb_data
);
  localparam int NBYTES = XLEN / 8;
  localparam int CW     = $clog2(NBYTES);

  ldd_state_t      state;
  ldd_op_t         dec, op_q;
  logic [AW-1:0]   ea, ea_q;
  logic [XLEN-1:0] pc_q;
  logic            illegal_q;
  logic [XLEN-1:0] word;
  logic [CW-1:0]   cnt;
  logic            last, take;

  ldd_decode u_dec (.instr(instr), .op(dec));

  ldd_agen #(.XLEN(XLEN), .AW(AW)) u_agen (
    .base_zero (op_q.ra == 5'd0 && !op_q.upd),
    .use_index (op_q.idx),
    .ds        (op_q.ds),
    .a_val     (rf_a_data),
    .b_val     (rf_b_data),
    .ea        (ea)
  );

  assign take = mem_req_valid && mem_req_ready;

  ldd_gather #(.NBYTES(NBYTES)) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state == S_AGEN),
    .take    (take),
    .byte_in (mem_rsp_data),
    .word    (word),
    .cnt     (cnt),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= '0;
      ea_q      <= '0;
      pc_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin  // R10: only sampled here
          op_q <= dec;
          pc_q <= pc_in;
          if (dec.legal) state <= S_AGEN;
          else           illegal_q <= 1'b1;  // R2
        end
        S_AGEN: begin
          ea_q  <= ea;
          state <= S_FETCH;
        end
        S_FETCH:   if (take && last) state <= S_WR_DST;
        S_WR_DST:  state <= op_q.upd ? S_WR_BASE : S_DONE;
        S_WR_BASE: state <= S_DONE;
        S_DONE:    state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_en   = 1'b0;
    wb_idx  = op_q.rt;
    wb_data = word;
    if (state == S_WR_DST) begin
      wb_en = 1'b1;
    end else if (state == S_WR_BASE) begin
      wb_en   = 1'b1;                              // R8
      wb_idx  = op_q.ra;
      wb_data = {{(XLEN-AW){1'b0}}, ea_q};
    end
  end

  assign busy          = (state != S_IDLE);
  assign done          = (state == S_DONE);
  assign illegal       = illegal_q;
  assign pc_next       = pc_q + XLEN'(4);
  assign rf_a_idx      = op_q.ra;
  assign rf_b_idx      = op_q.rb;
  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_addr  = ea_q + AW'(cnt);          // R5: wraps mod 2^AW

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mem_req_valid) |=> (!mem_req_valid || mem_req_addr == $past(mem_req_addr) + 1'b1));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req_valid && !wb_en && !done));

  assert_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wb_en));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal, wb_en, mem_req_valid}));
endmodule

// File: tb/ldd_exec_unit_bench.sv
module ldd_exec_unit_bench;
  typedef struct packed {
    logic [31:0] instr;
    logic [63:0] a_val;
    logic [63:0] b_val;
    logic [31:0] ea;
  } vec_t;

  function automatic logic [31:0] enc_ds(int rt, int ra, logic [13:0] ds, logic [1:0] xo);
    return {6'd58, 5'(rt), 5'(ra), ds, xo};
  endfunction
  function automatic logic [31:0] enc_x(int rt, int ra, int rb, int xo);
    return {6'd31, 5'(rt), 5'(ra), 5'(rb), 10'(xo), 1'b0};
  endfunction

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{enc_ds(3, 4, 14'd2, 2'd0),     64'h1000,               64'h0,   32'h0000_1008},
    '{enc_ds(5, 0, 14'h3FFF, 2'd0),  64'h7777_0000,          64'h0,   32'hFFFF_FFFC},
    '{enc_ds(6, 7, 14'd4, 2'd1),     64'h2003,               64'h0,   32'h0000_2013},
    '{enc_x(8, 0, 9, 21),            64'h7777_0000,          64'h300, 32'h0000_0300},
    '{enc_x(10, 11, 12, 53),         64'hFFFF_FFFF_0000_0010, 64'h20, 32'h0000_0030},
    '{enc_ds(13, 0, 14'd1, 2'd1),    64'h4000,               64'h0,   32'h0000_4004},
    '{enc_x(14, 14, 15, 53),         64'h500,                64'h7,   32'h0000_0507},
    '{enc_ds(16, 17, 14'h1FFF, 2'd0), 64'h10000,             64'h0,   32'h0001_7FFC},
    '{enc_ds(18, 19, 14'd8, 2'd0),   64'hFFFF_FFFF_FFFF_FFF0, 64'h0,  32'h0000_0010}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] pc_in = '0;
  logic        busy, done, illegal;
  logic [63:0] pc_next;
  logic [4:0]  rf_a_idx, rf_b_idx, wb_idx;
  logic [63:0] rf_a_data, rf_b_data, wb_data;
  logic        mem_req_valid, mem_req_ready, wb_en;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_rsp_data;

  logic [63:0] gpr [32];
  logic        pre_en = 1'b0;
  logic [4:0]  pre_idx = '0;
  logic [63:0] pre_val = '0;
  logic        stall = 1'b0;
  int          cyc = 0, nwr = 0, nacc = 0, ndone = 0, nill = 0, last_wr_cyc = 0;
  logic [31:0] alog [256];
  int          tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return (a[7:0] * 8'd3) ^ a[31:24] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [63:0] be_load(logic [31:0] a);
    logic [63:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[55:0], mem_byte(a + 32'(i))};
    return v;
  endfunction

  assign rf_a_data     = gpr[rf_a_idx];
  assign rf_b_data     = gpr[rf_b_idx];
  assign mem_rsp_data  = mem_byte(mem_req_addr);
  assign mem_req_ready = stall ? cyc[0] : 1'b1;

  ldd_exec_unit u_ldd_exec_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
    .busy(busy), .done(done), .illegal(illegal), .pc_next(pc_next),
    .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_data(mem_rsp_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pre_en) gpr[pre_idx] <= pre_val;
    else if (wb_en) begin
      gpr[wb_idx] <= wb_data;
      nwr         <= nwr + 1;
      last_wr_cyc <= cyc;
    end
    if (mem_req_valid && mem_req_ready) begin
      alog[nacc[7:0]] <= mem_req_addr;
      nacc <= nacc + 1;
    end
    if (done)    ndone <= ndone + 1;
    if (illegal) nill  <= nill + 1;
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preset(int idx, logic [63:0] val);
    @(negedge clk);
    pre_en = 1'b1; pre_idx = 5'(idx); pre_val = val;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic run_vec(int k, bit intrude);
    vec_t v = VECS[k];
    int rt = int'(v.instr[25:21]);
    int ra = int'(v.instr[20:16]);
    int rb = int'(v.instr[15:11]);
    bit xf = (v.instr[31:26] == 6'd31);
    bit upd = xf ? (v.instr[10:1] == 10'd53) : v.instr[0];
    int w0, a0, i0;
    bit seen;
    logic [63:0] exp_rt;
    for (int r = 0; r < 32; r++) preset(r, 64'hC0DE_0000_0000_0000 | 64'(r));
    preset(ra, v.a_val);
    if (xf) preset(rb, v.b_val);
    stall = k[0];
    w0 = nwr; a0 = nacc; i0 = nill;
    @(negedge clk);
    instr = v.instr; pc_in = 64'h8000_0000 + 64'(k * 16); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (4) @(negedge clk);
      instr = 32'hFFFF_FFFF; start = 1'b1;   // R10: arrives mid-fetch
      @(negedge clk);
      start = 1'b0;
      instr = v.instr;
    end
    wait_done(seen);
    check(seen, "R9", "done seen", 64'(seen), 64'd1);
    check(last_wr_cyc == cyc - 1, "R9", "done follows last write", 64'(last_wr_cyc), 64'(cyc - 1));
    check(pc_next == pc_in + 64'd4, "R9", "pc_next", pc_next, pc_in + 64'd4);
    check(nacc - a0 == 8, "R6", "handshake count", 64'(nacc - a0), 64'd8);
    for (int i = 0; i < 8; i++)
      check(alog[8'(a0 + i)] == v.ea + 32'(i), "R5", "byte address", 64'(alog[8'(a0 + i)]), 64'(v.ea + 32'(i)));
    check(nwr - w0 == (upd ? 2 : 1), "R8", "write count", 64'(nwr - w0), upd ? 64'd2 : 64'd1);
    exp_rt = (upd && ra == rt) ? {32'h0, v.ea} : be_load(v.ea);
    check(gpr[rt] == exp_rt, "R7", "destination value", gpr[rt], exp_rt);
    if (upd)
      check(gpr[ra] == {32'h0, v.ea}, "R8", "base written with EA", gpr[ra], {32'h0, v.ea});
    else if (ra == 0)
      check(gpr[0] == v.a_val, "R4", "register 0 untouched", gpr[0], v.a_val);
    if (intrude)
      check(nill == i0, "R10", "start while busy ignored", 64'(nill - i0), 64'd0);
    @(negedge clk);
    check(!done, "R9", "done single cycle", 64'(done), 64'd0);
  endtask

  task automatic run_bad(logic [31:0] w, string tag);
    int w0 = nwr, a0 = nacc, d0 = ndone;
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(illegal == 1'b1, "R2", {"illegal raised ", tag}, 64'(illegal), 64'd1);
    @(negedge clk);
    check(illegal == 1'b0, "R2", {"illegal one cycle ", tag}, 64'(illegal), 64'd0);
    repeat (12) @(negedge clk);
    check(nwr == w0 && nacc == a0 && ndone == d0, "R2", {"no side effects ", tag},
          64'(nwr - w0 + nacc - a0 + ndone - d0), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !illegal && !mem_req_valid && !wb_en, "R9", "reset state",
          {59'd0, busy, done, illegal, mem_req_valid, wb_en}, 64'd0);
    rst_n = 1'b1;
    // R1 R3 R4 R5 R7 R8: table walk, stalls on odd entries
    for (int k = 0; k < NV; k++) run_vec(k, 1'b0);
    // R10: start strobed during a stalled fetch
    run_vec(3, 1'b1);
    run_vec(6, 1'b1);
    // R2: words outside the four encodings
    run_bad(enc_ds(3, 4, 14'd2, 2'd2), "ds xo=2");
    run_bad(enc_ds(3, 4, 14'd2, 2'd3), "ds xo=3");
    run_bad(enc_x(8, 1, 9, 21) | 32'h1, "indexed Rc=1");
    run_bad(enc_x(8, 1, 9, 22), "xo=22");
    run_bad({6'd32, 26'h0}, "opcode 32");
    // R1: a legal load right after illegal words still works
    run_vec(0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule